// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Cell

This block is one logic cell of a small sum-of-products programmable fabric. Its whole personality comes from static configuration inputs. From a 40-wide array input it builds five product terms. Each term is an AND of any mix of true and inverted array signals. A mask picks which terms feed a local OR. The OR also takes a cascade input from a neighbouring cell, so several cells can be chained into one wide sum, and the result is passed on through a cascade output. A configuration bit can then invert the sum.

The sum, after the optional inversion, feeds a storage element that works as a D flip-flop, a T flip-flop or a transparent latch. Its clock is one of three global clocks or a product term. Its clear is the global clear or a product term. The pin output can be taken from the register or straight from the combinational sum. The register always drives a separate buried feedback, so the pin can stay combinational while the register is still in use. A further term drives an inverted foldback output, and an output-enable selector picks a global enable line, a product term, or a constant on.

Inside the fabric, the cell is sampled by a fast system clock `clk`. A storage clock counts as having a rising edge in a `clk` cycle when it is seen high in that cycle after being low in the cycle before. The register result is visible after the next `clk` edge. Clear and latch transparency act on the outputs combinationally.

Top module: `plc_cell`

## Requirements
- R1: Term k (k = 0..4) uses bits [k*40 +: 40] of `cfg_pt_true` and `cfg_pt_comp`. It is 1 when every array bit selected in true form is 1 and every bit selected in inverted form is 0. A term with no selected bits is 1. A term that selects one bit in both forms is 0.
- R2: `casc_out` is the OR of `casc_in` and every term k whose `cfg_sum_mask[k]` is 1. With `casc_in` at 0, it equals the local sum alone.
- R3: The data value is the sum XOR `cfg_xor_inv`.
- R4: With `cfg_mode` 0 or 3 (D), the register loads the data value on a rising edge of the selected storage clock and holds it otherwise.
- R5: With `cfg_mode` 1 (T), the register inverts its value on a rising edge when the data value is 1, and holds it otherwise.
- R6: With `cfg_mode` 2 (latch), the register output follows the data value at once while the selected storage clock is high. It keeps the last value when the clock is low.
- R7: `cfg_clk_sel` 0, 1 or 2 selects `gclk[0..2]`. A value of 3 selects term 1.
- R8: `cfg_clr_sel` 0 selects `gclr` and 1 selects term 2. An active clear forces the register output to 0 in the same cycle, leaves the register at 0, and wins over any clock edge.
- R9: `pin_oe` is `goe[cfg_oe_sel]` for `cfg_oe_sel` 0..5. It is term 3 for a value of 6 and 1 for a value of 7.
- R10: `pin_out` is the register output when `cfg_out_reg` is 1 and the data value when it is 0. `fb_out` is always the register output.
- R11: `fold_out` is the inverse of term 4.
- R12: After reset the register holds 0 and no storage-clock edge is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | fabric sampling clock |
| rst_n | input | 1 | active-low asynchronous reset |
| arr_in | input | 40 | selected array signals |
| casc_in | input | 1 | sum chained in from the neighbouring cell |
| gclk | input | 3 | global storage clocks |
| gclr | input | 1 | global clear |
| goe | input | 6 | global output-enable lines |
| cfg_pt_true | input | 200 | true-literal selection, 40 bits per term |
| cfg_pt_comp | input | 200 | inverted-literal selection, 40 bits per term |
| cfg_sum_mask | input | 5 | terms included in the sum |
| cfg_xor_inv | input | 1 | invert the sum |
| cfg_mode | input | 2 | storage mode: 0/3 D, 1 T, 2 latch |
| cfg_clk_sel | input | 2 | storage clock source |
| cfg_clr_sel | input | 1 | clear source |
| cfg_oe_sel | input | 3 | output-enable source |
| cfg_out_reg | input | 1 | pin from register (1) or from the data value (0) |
| pin_out | output | 1 | pin data |
| pin_oe | output | 1 | pin enable |
| fb_out | output | 1 | buried register feedback |
| fold_out | output | 1 | inverted foldback term |
| casc_out | output | 1 | chained sum to the next cell |

## Verification
A corrupted stored bit shows on `fb_out` in the very `clk` cycle after the faulty update, whatever the pin mode is. It also shows on `pin_out` when the register path is chosen. A stale storage-clock history shows up as a missed or doubled capture on the next storage-clock pulse, and in T mode the wrong parity then stays until a clear. Faults in the term array or the selectors show on `casc_out`, `fold_out` or `pin_oe` with no delay. The bench therefore compares every output against a behavioural model on every cycle.

// File: rtl/plc_pkg.sv
package plc_pkg;
  typedef enum logic [1:0] {
    ST_DFF     = 2'd0,
    ST_TFF     = 2'd1,
    ST_LATCH   = 2'd2,
    ST_DFF_ALT = 2'd3
  } store_mode_e;
endpackage

// File: rtl/plc_pterms.sv
module plc_pterms #(
  parameter int N_IN = 40,
  parameter int N_PT = 5
) (
  input  logic [N_IN-1:0]      arr_in,
  input  logic [N_PT*N_IN-1:0] use_true,
  input  logic [N_PT*N_IN-1:0] use_comp,
  output logic [N_PT-1:0]      term
);
  // a literal blocks the term when its chosen polarity is not met
  function automatic logic and_lits(input logic [N_IN-1:0] a,
                                    input logic [N_IN-1:0] t,
                                    input logic [N_IN-1:0] c);
    return &((a | ~t) & (~a | ~c));
  endfunction

  for (genvar k = 0; k < N_PT; k++) begin : g_term
    assign term[k] = and_lits(arr_in, use_true[k*N_IN +: N_IN], use_comp[k*N_IN +: N_IN]);
  end
endmodule

// File: rtl/plc_sum.sv
module plc_sum #(
  parameter int N_PT = 5
) (
  input  logic [N_PT-1:0] term,
  input  logic [N_PT-1:0] mask,
  input  logic            casc_in,
  input  logic            inv,
  output logic            casc_out,
  output logic            data
);
  function automatic logic chain_or(input logic [N_PT-1:0] t,
                                    input logic [N_PT-1:0] m,
                                    input logic cin);
    return (|(t & m)) | cin;
  endfunction

  assign casc_out = chain_or(term, mask, casc_in);
  assign data     = casc_out ^ inv;
endmodule

// File: rtl/plc_store.sv
module plc_store
  import plc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  store_mode_e mode,
  input  logic        ck,
  input  logic        clr,
  input  logic        d,
  output logic        q
);
  logic ck_prev;
  logic state_r;
  logic rise;
  logic is_latch;
  logic is_tff;

  assign rise     = ck & ~ck_prev;
  assign is_latch = (mode == ST_LATCH);
  assign is_tff   = (mode == ST_TFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_r <= 1'b0;
      ck_prev <= 1'b0;
    end else begin
      ck_prev <= ck;
      if (clr) begin
        state_r <= 1'b0;
      end else begin
        case (mode)
          ST_TFF:   if (rise && d) state_r <= ~state_r;
          ST_LATCH: if (ck) state_r <= d;
          default:  if (rise) state_r <= d;
        endcase
      end
    end
  end

  assign q = clr ? 1'b0 : ((is_latch && ck) ? d : state_r);

  AST_D_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_latch && !is_tff && rise && !clr) |=> (state_r == $past(d))); // R4
  AST_T_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (is_tff && rise && d && !clr) |=> (state_r != $past(state_r))); // R5
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (is_latch && !ck && !clr) |=> (state_r == $past(state_r))); // R6
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !state_r); // R8
endmodule

// File: rtl/plc_cell.sv
module plc_cell
  import plc_pkg::*;
#(
  parameter int N_IN   = 40,
  parameter int N_PT   = 5,
  parameter int N_GCLK = 3,
  parameter int N_GOE  = 6,
  parameter int CLK_PT = 1,
  parameter int CLR_PT = 2,
  parameter int OE_PT  = 3,
  parameter int FLD_PT = 4,
  localparam int CKS_W = $clog2(N_GCLK + 1),
  localparam int OES_W = $clog2(N_GOE + 2)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_IN-1:0]      arr_in,
  input  logic                 casc_in,
  input  logic [N_GCLK-1:0]    gclk,
  input  logic                 gclr,
  input  logic [N_GOE-1:0]     goe,
  input  logic [N_PT*N_IN-1:0] cfg_pt_true,
  input  logic [N_PT*N_IN-1:0] cfg_pt_comp,
  input  logic [N_PT-1:0]      cfg_sum_mask,
  input  logic                 cfg_xor_inv,
  input  logic [1:0]           cfg_mode,
  input  logic [CKS_W-1:0]     cfg_clk_sel,
  input  logic                 cfg_clr_sel,
  input  logic [OES_W-1:0]     cfg_oe_sel,
  input  logic                 cfg_out_reg,
  output logic                 pin_out,
  output logic                 pin_oe,
  output logic                 fb_out,
  output logic                 fold_out,
  output logic                 casc_out
);
  localparam logic [CKS_W-1:0] CK_PT_CODE = CKS_W'(N_GCLK);
  localparam logic [OES_W-1:0] OE_PT_CODE = OES_W'(N_GOE);

  logic [N_PT-1:0] term;
  logic            data;
  logic            ck_act;
  logic            clr_act;
  logic            reg_q;

  plc_pterms #(.N_IN(N_IN), .N_PT(N_PT)) u_terms (
    .arr_in   (arr_in),
    .use_true (cfg_pt_true),
    .use_comp (cfg_pt_comp),
    .term     (term)
  );

  plc_sum #(.N_PT(N_PT)) u_sum (
    .term     (term),
    .mask     (cfg_sum_mask),
    .casc_in  (casc_in),
    .inv      (cfg_xor_inv),
    .casc_out (casc_out),
    .data     (data)
  );

  assign ck_act  = (cfg_clk_sel < CK_PT_CODE) ? gclk[cfg_clk_sel] : term[CLK_PT];
  assign clr_act = cfg_clr_sel ? term[CLR_PT] : gclr;

  plc_store u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .mode  (store_mode_e'(cfg_mode)),
    .ck    (ck_act),
    .clr   (clr_act),
    .d     (data),
    .q     (reg_q)
  );

  always_comb begin
    if (cfg_oe_sel < OE_PT_CODE)       pin_oe = goe[cfg_oe_sel];
    else if (cfg_oe_sel == OE_PT_CODE) pin_oe = term[OE_PT];
    else                               pin_oe = 1'b1;
  end

  assign pin_out  = cfg_out_reg ? reg_q : data;
  assign fb_out   = reg_q;
  assign fold_out = ~term[FLD_PT];

  AST_CASC_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    casc_in |-> casc_out); // R2
  AST_OE_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_oe_sel > OE_PT_CODE) |-> pin_oe); // R9
  AST_PIN_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_act && cfg_out_reg) |-> (!pin_out && !fb_out)); // R8
endmodule

// File: tb/plc_cell_test.sv
module plc_cell_test;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 40;
  localparam int NP = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NI-1:0] arr_in = '0;
  logic casc_in = 1'b0;
  logic [2:0] gclk = '0;
  logic gclr = 1'b0;
  logic [5:0] goe = '0;
  logic [NP*NI-1:0] cfg_pt_true = '0;
  logic [NP*NI-1:0] cfg_pt_comp = '0;
  logic [NP-1:0] cfg_sum_mask = '0;
  logic cfg_xor_inv = 1'b0;
  logic [1:0] cfg_mode = 2'd0;
  logic [1:0] cfg_clk_sel = 2'd0;
  logic cfg_clr_sel = 1'b0;
  logic [2:0] cfg_oe_sel = 3'd0;
  logic cfg_out_reg = 1'b1;
  logic pin_out, pin_oe, fb_out, fold_out, casc_out;

  int total = 0;
  int bad = 0;
  bit m_st = 1'b0;
  bit m_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  plc_cell uut (
    .clk(clk), .rst_n(rst_n), .arr_in(arr_in), .casc_in(casc_in), .gclk(gclk),
    .gclr(gclr), .goe(goe), .cfg_pt_true(cfg_pt_true), .cfg_pt_comp(cfg_pt_comp),
    .cfg_sum_mask(cfg_sum_mask), .cfg_xor_inv(cfg_xor_inv), .cfg_mode(cfg_mode),
    .cfg_clk_sel(cfg_clk_sel), .cfg_clr_sel(cfg_clr_sel), .cfg_oe_sel(cfg_oe_sel),
    .cfg_out_reg(cfg_out_reg), .pin_out(pin_out), .pin_oe(pin_oe), .fb_out(fb_out),
    .fold_out(fold_out), .casc_out(casc_out)
  );

  // behavioural reference
  function automatic bit f_pt(int k);
    for (int i = 0; i < NI; i++) begin
      if (cfg_pt_true[k*NI+i] === 1'b1 && arr_in[i] !== 1'b1) return 1'b0;
      if (cfg_pt_comp[k*NI+i] === 1'b1 && arr_in[i] === 1'b1) return 1'b0;
    end
    return 1'b1;
  endfunction
  function automatic bit f_sum();
    bit s = casc_in;
    for (int k = 0; k < NP; k++) if (cfg_sum_mask[k] && f_pt(k)) s = 1'b1;
    return s;
  endfunction
  function automatic bit f_d();  return f_sum() != cfg_xor_inv; endfunction
  function automatic bit f_ck(); return (cfg_clk_sel == 2'd3) ? f_pt(1) : gclk[cfg_clk_sel]; endfunction
  function automatic bit f_clr(); return cfg_clr_sel ? f_pt(2) : gclr; endfunction
  function automatic bit f_q();
    if (f_clr()) return 1'b0;
    if (cfg_mode == 2'd2 && f_ck()) return f_d();
    return m_st;
  endfunction
  function automatic bit f_oe();
    if (cfg_oe_sel == 3'd7) return 1'b1;
    if (cfg_oe_sel == 3'd6) return f_pt(3);
    return goe[cfg_oe_sel];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 1'b0; m_prev = 1'b0;
    end else begin
      if (f_clr()) m_st = 1'b0;
      else if (cfg_mode == 2'd1) begin if (f_ck() && !m_prev && f_d()) m_st = !m_st; end
      else if (cfg_mode == 2'd2) begin if (f_ck()) m_st = f_d(); end
      else if (f_ck() && !m_prev) m_st = f_d();
      m_prev = f_ck();
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R2 casc_out model", casc_out, f_sum());
    chk("R9 pin_oe model", pin_oe, f_oe());
    chk("R11 fold_out model", fold_out, !f_pt(4));
    chk("R4/R5/R6/R8 fb_out model", fb_out, f_q());
    chk("R10 pin_out model", pin_out, cfg_out_reg ? f_q() : f_d());
  end

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick();
    // R12: register empty after reset; all-empty terms make fold 0
    chk("R12 fb_out after reset", fb_out, 1'b0);
    chk("R11 empty term4 gives fold 0", fold_out, 1'b0);
    for (int k = 0; k < NP; k++) cfg_pt_true[k*NI + k] = 1'b1;
    cfg_pt_comp[7] = 1'b1;
    cfg_sum_mask = 5'b00001;
    cfg_out_reg = 1'b0;
    // R1: term0 = a0 & ~a7
    arr_in[0] = 1'b1; #2;
    chk("R1 term true literal met", casc_out, 1'b1);
    arr_in[7] = 1'b1; #2;
    chk("R1 inverted literal blocks", casc_out, 1'b0);
    arr_in[7] = 1'b0; cfg_pt_comp[0] = 1'b1; #2;
    chk("R1 both polarities give 0", casc_out, 1'b0);
    cfg_pt_comp[0] = 1'b0; #2;
    // R2 cascade
    arr_in[0] = 1'b0; casc_in = 1'b1; #2;
    chk("R2 casc_in passes", casc_out, 1'b1);
    casc_in = 1'b0; #2;
    chk("R2 casc_in 0 keeps local", casc_out, 1'b0);
    // R3 inversion, R10 combinational pin
    cfg_xor_inv = 1'b1; #2;
    chk("R3 inverted sum on pin", pin_out, 1'b1);
    cfg_xor_inv = 1'b0; #2;
    chk("R10 comb pin follows data", pin_out, 1'b0);
    tick();
    // R4 D mode on gclk0
    cfg_out_reg = 1'b1; arr_in[0] = 1'b1; gclk[0] = 1'b1; #2;
    chk("R4 before edge holds", pin_out, 1'b0);
    tick();
    chk("R4 captured on edge", pin_out, 1'b1);
    arr_in[0] = 1'b0; tick();
    chk("R4 held while clock high", pin_out, 1'b1);
    // R10 buried register: pin comb, fb keeps register
    cfg_out_reg = 1'b0; #2;
    chk("R10 pin comb", pin_out, 1'b0);
    chk("R10 fb buried", fb_out, 1'b1);
    cfg_out_reg = 1'b1;
    gclk[0] = 1'b0; tick(); gclk[0] = 1'b1; tick();
    chk("R4 second edge loads 0", pin_out, 1'b0);
    gclk[0] = 1'b0; tick();
    // R5 T mode
    cfg_mode = 2'd1; arr_in[0] = 1'b1;
    gclk[0] = 1'b1; tick(); gclk[0] = 1'b0; tick();
    chk("R5 toggles to 1", fb_out, 1'b1);
    gclk[0] = 1'b1; tick(); gclk[0] = 1'b0; tick();
    chk("R5 toggles to 0", fb_out, 1'b0);
    arr_in[0] = 1'b0;
    gclk[0] = 1'b1; tick(); gclk[0] = 1'b0; tick();
    chk("R5 no toggle on data 0", fb_out, 1'b0);
    // R6 latch
    cfg_mode = 2'd2; gclk[0] = 1'b1; arr_in[0] = 1'b1; #2;
    chk("R6 transparent at once", pin_out, 1'b1);
    tick(); gclk[0] = 1'b0; tick(); arr_in[0] = 1'b0; #2;
    chk("R6 holds when clock low", pin_out, 1'b1);
    tick(2);
    chk("R6 still held", fb_out, 1'b1);
    // R8 global clear
    gclr = 1'b1; #2;
    chk("R8 global clear immediate", pin_out, 1'b0);
    tick(); gclr = 1'b0; tick();
    chk("R8 stays cleared", fb_out, 1'b0);
    // R7 clock from term1 (a1), D mode
    cfg_mode = 2'd0; cfg_clk_sel = 2'd3; arr_in[0] = 1'b1;
    gclk = 3'b111; tick(2);
    chk("R7 globals ignored when term clock picked", fb_out, 1'b0);
    arr_in[1] = 1'b1; tick();
    chk("R7 term1 edge captures", fb_out, 1'b1);
    arr_in[1] = 1'b0; gclk = 3'b000;
    // R7 gclk2
    cfg_clk_sel = 2'd2; arr_in[0] = 1'b0; tick();
    gclk[2] = 1'b1; tick();
    chk("R7 gclk2 edge captures", fb_out, 1'b0);
    // R8 term clear wins over edge
    arr_in[0] = 1'b1; gclk[2] = 1'b0; tick();
    cfg_clr_sel = 1'b1; arr_in[2] = 1'b1; gclk[2] = 1'b1; tick();
    chk("R8 term2 clear beats edge", fb_out, 1'b0);
    arr_in[2] = 1'b0; gclk[2] = 1'b0; tick();
    gclk[2] = 1'b1; tick();
    chk("R8 release then capture", fb_out, 1'b1);
    // R9 output enable
    for (int s = 0; s < 6; s++) begin
      cfg_oe_sel = 3'(s); goe = 6'(1 << s); #2;
      chk("R9 goe selected line", pin_oe, 1'b1);
      goe = ~goe; #2;
      chk("R9 goe other lines ignored", pin_oe, 1'b0);
    end
    cfg_oe_sel = 3'd6; arr_in[3] = 1'b1; #2;
    chk("R9 term3 enable", pin_oe, 1'b1);
    arr_in[3] = 1'b0; #2;
    chk("R9 term3 off", pin_oe, 1'b0);
    cfg_oe_sel = 3'd7; #2;
    chk("R9 always on", pin_oe, 1'b1);
    // R11 foldback
    arr_in[4] = 1'b0; #2;
    chk("R11 fold high when term4 0", fold_out, 1'b1);
    arr_in[4] = 1'b1; #2;
    chk("R11 fold low when term4 1", fold_out, 1'b0);
    tick(2);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule